// File: doc/BRIEF.md
# Burst Extended-Data-Out DRAM Device Model

This block is a synthesizable, cycle-level model of a burst extended-data-out DRAM device. It is driven by active-low row strobe, column strobe, write enable and output enable pins, and it takes row and column numbers on one shared address bus. Each clock edge on which a strobe is sampled low counts as one strobe cycle. Storage is a small register array that has one word per row/column pair.

To read, a controller opens a row by pulling the row strobe low. It then gives one column number on the first column-strobe cycle. That cycle only fills an internal output pipeline register, so no data appears yet. On every later column-strobe cycle the device drives one word and fetches the next one itself. A two-bit counter inside the device advances the column within its aligned group of four, so the controller never sends another column. Raising the row strobe ends the burst. Single-cell writes may be issued at any time while a row is open.

Top module: `bedo_dram`

## Requirements
- R1: On an edge where ras_n is low and no row is open, the device latches addr as the row number. That row stays selected until ras_n is sampled high.
- R2: The first read strobe cycle of a burst (cas_n low, we_n high, row open) latches addr as the column. It loads that cell into the pipeline and drives nothing: dq_drive stays 0 after that edge.
- R3: Each later read strobe cycle presents the pipelined word on dq_out with dq_drive 1, which is one word per cycle. The address pins are ignored during this cycle.
- R4: The burst column wraps inside its aligned group of four. Bits [1:0] count up modulo 4 and the upper column bits stay fixed. A burst started at column 6 yields columns 6, 7, 4, 5, 6, ...
- R5: A cycle with cas_n high holds the driven word and the burst position unchanged.
- R6: A write strobe cycle (cas_n low, we_n low, row open) stores dq_in at the column on addr. It neither advances nor starts a read burst, and the driven word is unchanged.
- R7: A write to the column currently held in the pipeline also updates the pipeline, so the next read strobe cycle returns the new data.
- R8: An edge with ras_n high ends the burst and clears the pipeline, so dq_drive is 0 afterwards. The next strobe cycle after the row is reopened counts as a first cycle again.
- R9: dq_drive is 1 only while oe_n is low and a word has been presented. dq_drive = 0 means the data outputs are high impedance.
- R10: While rst_n is low, and after it is released, no row is open and dq_drive is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, qualified by cas_n |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column number |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, meaningful while dq_drive is 1 |
| dq_drive | output | 1 | 1 while the data outputs drive; 0 is high impedance |

## Verification
The bench starts a burst near the top of an aligned group. A counter that carried into the upper column bits would then return the wrong cells on the third word. It issues a first strobe cycle and checks that nothing is driven, which catches a design that skips the pipeline stage or shows stale data. Writes are placed inside a running burst. A design that advanced on writes would skip a word, and one without pipeline forwarding would return the stale cell. The bench also closes and reopens a row, and resets in the middle of a burst. Each checks that the outputs float and that the next column strobe is treated as a fresh start rather than a continuation.

// File: rtl/bedo_pkg.sv
package bedo_pkg;
  localparam int unsigned GROUP_BITS = 2;
  localparam int unsigned GROUP_LEN  = 1 << GROUP_BITS;

  // next column inside the aligned group: low bits wrap, upper bits fixed
  function automatic logic [15:0] wrap_next(input logic [15:0] col);
    logic [15:0] r;
    r = col;
    r[GROUP_BITS-1:0] = col[GROUP_BITS-1:0] + 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/bedo_row_latch.sv
module bedo_row_latch #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              row_open,
  output logic [ADDR_W-1:0] row_q
);
  logic              open_d;
  logic              row_en;
  logic [ADDR_W-1:0] row_d;

  always_comb begin
    open_d = row_open;
    row_en = 1'b0;
    row_d  = row_q;
    if (ras_n) begin
      open_d = 1'b0;
    end else if (!row_open) begin
      open_d = 1'b1;
      row_en = 1'b1;
      row_d  = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      row_q    <= '0;
    end else begin
      row_open <= open_d;
      if (row_en) row_q <= row_d;
    end
  end
endmodule

// File: rtl/bedo_burst_ctrl.sv
module bedo_burst_ctrl
  import bedo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              row_open,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_first,
  output logic              rd_next,
  output logic              wr_cyc,
  output logic              burst_q,
  output logic [ADDR_W-1:0] col_q,
  output logic [ADDR_W-1:0] rd_col
);
  logic              cas_cyc;
  logic              burst_d;
  logic              col_en;
  logic [ADDR_W-1:0] col_d;
  logic [ADDR_W-1:0] col_inc;
  logic [15:0]       col_wide;
  logic [15:0]       inc_wide;

  always_comb begin
    col_wide               = '0;
    col_wide[ADDR_W-1:0]   = col_q;
    inc_wide               = wrap_next(col_wide);
    col_inc                = inc_wide[ADDR_W-1:0];
  end

  assign cas_cyc  = row_open & ~ras_n & ~cas_n;
  assign rd_first = cas_cyc & we_n & ~burst_q;
  assign rd_next  = cas_cyc & we_n & burst_q;
  assign wr_cyc   = cas_cyc & ~we_n;
  assign rd_col   = burst_q ? col_inc : addr;

  always_comb begin
    burst_d = burst_q;
    col_en  = 1'b0;
    col_d   = col_q;
    if (ras_n) begin
      burst_d = 1'b0;
    end else if (rd_first) begin
      burst_d = 1'b1;
      col_en  = 1'b1;
      col_d   = addr;
    end else if (rd_next) begin
      col_en  = 1'b1;
      col_d   = col_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      col_q   <= '0;
    end else begin
      burst_q <= burst_d;
      if (col_en) col_q <= col_d;
    end
  end
endmodule

// File: rtl/bedo_cell_array.sv
module bedo_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_col,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CELL_AW = 2 * ADDR_W;
  localparam int CELLS   = 1 << CELL_AW;

  logic [DATA_W-1:0] cells [CELLS];
  logic [CELL_AW-1:0] wr_idx;
  logic [CELL_AW-1:0] rd_idx;

  assign wr_idx  = {row, wr_col};
  assign rd_idx  = {row, rd_col};
  assign rd_data = cells[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/bedo_out_stage.sv
module bedo_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              shift,
  input  logic              fwd,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] fwd_data,
  input  logic              oe_n,
  output logic              valid_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              drive
);
  logic [DATA_W-1:0] pipe_q;
  logic [DATA_W-1:0] pipe_d;
  logic              pipe_en;
  logic              valid_d;

  always_comb begin
    pipe_en = load | fwd;
    pipe_d  = load ? rd_data : fwd_data;
    valid_d = valid_q;
    if (clr)        valid_d = 1'b0;
    else if (shift) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q  <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (pipe_en) pipe_q <= pipe_d;
      if (shift)   dout_q <= pipe_q;
    end
  end

  assign drive = valid_q & ~oe_n;
endmodule

// File: rtl/bedo_dram.sv
module bedo_dram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              row_open;
  logic [ADDR_W-1:0] row_q;
  logic              rd_first;
  logic              rd_next;
  logic              wr_cyc;
  logic              burst_q;
  logic [ADDR_W-1:0] col_q;
  logic [ADDR_W-1:0] rd_col;
  logic [DATA_W-1:0] rd_data;
  logic              fwd;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bedo_row_latch #(.ADDR_W(ADDR_W)) u_row (
    .clk(clk), .rst_n(rst_int_n), .ras_n(ras_n), .addr(addr),
    .row_open(row_open), .row_q(row_q)
  );

  bedo_burst_ctrl #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_int_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .row_open(row_open), .addr(addr), .rd_first(rd_first), .rd_next(rd_next),
    .wr_cyc(wr_cyc), .burst_q(burst_q), .col_q(col_q), .rd_col(rd_col)
  );

  bedo_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .wr_en(wr_cyc), .row(row_q), .wr_col(addr), .wr_data(dq_in),
    .rd_col(rd_col), .rd_data(rd_data)
  );

  assign fwd = wr_cyc & burst_q & (addr == col_q);

  bedo_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .clr(ras_n), .load(rd_first | rd_next),
    .shift(rd_next), .fwd(fwd), .rd_data(rd_data), .fwd_data(dq_in),
    .oe_n(oe_n), .valid_q(valid_q), .dout_q(dq_out), .drive(dq_drive)
  );
endmodule

// File: rtl/bedo_dram_chk.sv
module bedo_dram_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_drive,
  input logic              row_open,
  input logic              burst_q,
  input logic              valid_q,
  input logic [ADDR_W-1:0] col_q
);
  // R8: a high row strobe leaves the outputs floating
  a_r8_ras_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |=> !dq_drive);

  // R2: first read strobe cycle presents nothing
  a_r2_first_cas_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && !ras_n && !cas_n && we_n && !burst_q) |=> !valid_q);

  // R4: burst column wraps inside its aligned group of four
  a_r4_group_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && !ras_n && !cas_n && we_n && burst_q) |=>
      (col_q[ADDR_W-1:2] == $past(col_q[ADDR_W-1:2]) &&
       col_q[1:0] == $past(col_q[1:0]) + 2'd1));

  // R6: a write neither moves the burst nor changes the presented word
  a_r6_write_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && !ras_n && !cas_n && !we_n) |=> ($stable(col_q) && $stable(dq_out)));

  // R5: idle column strobe holds the word
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n) |=> $stable(dq_out));

  // R9: driving needs output enable
  a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> !oe_n);
endmodule

bind bedo_dram bedo_dram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_out(dq_out), .dq_drive(dq_drive), .row_open(row_open),
  .burst_q(burst_q), .valid_q(valid_q), .col_q(col_q)
);

// File: tb/bedo_dram_tb_top.sv
module bedo_dram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ras_n, cas_n, we_n, oe_n;
  logic [3:0] addr;
  logic [7:0] dq_in;
  logic [7:0] dq_out;
  logic       dq_drive;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  bedo_dram #(.ADDR_W(4), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  typedef struct packed {
    logic       ras_n;
    logic       cas_n;
    logic       we_n;
    logic       oe_n;
    logic [3:0] addr;
    logic [7:0] din;
    logic       exp_drv;
    logic [7:0] exp_dat;
  } vec_t;

  // pins: ras_n cas_n we_n oe_n addr din | expected drive, data after the edge
  localparam vec_t VECS [16] = '{
    '{1'b0,1'b1,1'b1,1'b0,4'd2,8'h00,1'b0,8'h00}, // R1 open row 2
    '{1'b0,1'b0,1'b0,1'b0,4'd4,8'hA0,1'b0,8'h00}, // R6 write col 4
    '{1'b0,1'b0,1'b0,1'b0,4'd5,8'hA1,1'b0,8'h00}, // R6
    '{1'b0,1'b0,1'b0,1'b0,4'd6,8'hA2,1'b0,8'h00}, // R6
    '{1'b0,1'b0,1'b0,1'b0,4'd7,8'hA3,1'b0,8'h00}, // R6
    '{1'b1,1'b1,1'b1,1'b0,4'd0,8'h00,1'b0,8'h00}, // R8 close
    '{1'b0,1'b1,1'b1,1'b0,4'd2,8'h00,1'b0,8'h00}, // R1 reopen row 2
    '{1'b0,1'b0,1'b1,1'b0,4'd6,8'h00,1'b0,8'h00}, // R2 first cas, col 6
    '{1'b0,1'b0,1'b1,1'b0,4'hF,8'h00,1'b1,8'hA2}, // R3 addr ignored
    '{1'b0,1'b0,1'b1,1'b0,4'h0,8'h00,1'b1,8'hA3}, // R3
    '{1'b0,1'b0,1'b1,1'b0,4'h9,8'h00,1'b1,8'hA0}, // R4 wrap to col 4
    '{1'b0,1'b0,1'b1,1'b0,4'h3,8'h00,1'b1,8'hA1}, // R4
    '{1'b0,1'b0,1'b1,1'b0,4'h1,8'h00,1'b1,8'hA2}, // R4 continues wrapping
    '{1'b0,1'b1,1'b1,1'b0,4'h1,8'h00,1'b1,8'hA2}, // R5 hold
    '{1'b0,1'b1,1'b1,1'b1,4'h1,8'h00,1'b0,8'h00}, // R9 oe high floats
    '{1'b1,1'b1,1'b1,1'b0,4'h0,8'h00,1'b0,8'h00}  // R8 close
  };

  task automatic step(input logic r, input logic c, input logic w, input logic o,
                      input logic [3:0] a, input logic [7:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; dq_in = d;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset drive", {7'd0, dq_drive}, 8'd0);
    rst_n = 1'b1;
    repeat (3) step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R10 after release drive", {7'd0, dq_drive}, 8'd0);

    for (int i = 0; i < 16; i++) begin
      step(VECS[i].ras_n, VECS[i].cas_n, VECS[i].we_n, VECS[i].oe_n,
           VECS[i].addr, VECS[i].din);
      check($sformatf("R3/R4 vec %0d drive", i), {7'd0, dq_drive}, {7'd0, VECS[i].exp_drv});
      if (VECS[i].exp_drv) check($sformatf("R3/R4 vec %0d data", i), dq_out, VECS[i].exp_dat);
    end

    // R1: row 3 holds its own data, different from row 2
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 8'h00);
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 8'h33);
    step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00);
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R1 row 2 col 4", dq_out, 8'hA0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00);
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 8'h00);
    check("R8 first cas after reopen silent", {7'd0, dq_drive}, 8'd0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R1 row 3 col 4", dq_out, 8'h33);
    step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00);

    // R6/R7: write inside a running burst, to the pipelined column 5
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 8'h00);   // first: pipe col 4
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);   // out A0, pipe col 5
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 8'h55);   // write col 5
    check("R6 write keeps word", dq_out, 8'hA0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R7 forwarded word", dq_out, 8'h55);
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 8'h66);   // write col 4, pipe holds col 6
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R6 no advance on write", dq_out, 8'hA2);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R4 wrap after writes", dq_out, 8'hA3);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R6 stored col 4", dq_out, 8'h66);

    // R10: reset in the middle of a burst
    rst_n = 1'b0;
    #1;
    check("R10 mid-burst reset floats", {7'd0, dq_drive}, 8'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (2) step(1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 8'h00);
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 8'h00);   // opens row 2
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 8'h00);
    check("R10 burst restarts silent", {7'd0, dq_drive}, 8'd0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R2 column from pins after reset", dq_out, 8'h55);
    step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00);
    check("R8 close floats", {7'd0, dq_drive}, 8'd0);

    done = 1'b1;
    finish_run();
  end
endmodule